// File: doc/BRIEF.md
# Barrier-Based Stackless Reconvergence Unit

This block tracks how the threads of one warp diverge and converge again without a PC/mask stack. Each thread holds its own program counter and a ready/blocked state. Each of a small number of named convergence barriers holds two masks: a participation mask and an arrival mask. All lanes of the warp are active. On every cycle the block picks one thread group, made of the ready threads that share the PC of the lowest-numbered ready thread. It presents that group as an executable mask together with its PC.

The surrounding issue logic reports what the chosen group did, one operation per cycle. A plain step advances the group's PCs. A branch sends the lanes named in a taken mask to a target and lets the other lanes of the group fall through. An add-barrier operation records the executing group as the participants of a barrier. A wait operation marks executing participants as arrived and blocks them. A wait behaves as a NOP for those lanes until the last participant arrives, and then every participant of that barrier becomes ready again. A misuse of barrier indices raises a sticky error flag.

Top module: `reconv_unit`

## Requirements
- R1: After reset every thread PC is 0, every thread is ready, no barrier is in use, errFlag is 0, so groupValid=1, groupPc=0 and execMask is all ones.
- R2: groupPc is the PC of the lowest-indexed ready thread, and execMask holds exactly the ready threads whose PC equals groupPc. When no thread is ready, groupValid=0 and execMask=0.
- R3: opCode 0 (step) with opValid sets the PC of each thread in execMask to PC+1, modulo 2^PC_W. Other PCs are unchanged.
- R4: opCode 1 (branch) sends each thread in execMask whose opTaken bit is 1 to opTarget. The other threads of execMask go to PC+1.
- R5: opCode 2 (add barrier) with an in-range opBar loads that barrier's participation mask with execMask, clears its arrival mask and marks it in use. The group's PCs advance by one.
- R6: opCode 3 (wait) on an in-use barrier sets the arrival bit of each thread that is both in execMask and a participant, and blocks those threads. The group's PCs advance by one.
- R7: A thread in execMask that is not a participant of the waited barrier stays ready and only advances its PC.
- R8: At the clock edge after an in-use barrier's arrival mask equals its participation mask, all of its participants become ready and the barrier leaves use. An add on the same barrier in that cycle takes precedence.
- R9: An add or wait with opBar >= NUM_BARS, or a wait on a barrier not in use, sets errFlag, which stays set until reset. That operation changes no barrier and blocks no thread, though the group's PCs still advance.
- R10: With opValid low, no PC, barrier or error state changes. Only pending releases take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is reported for the current group |
| opCode | input | 2 | 0 step, 1 branch, 2 add barrier, 3 wait |
| opBar | input | BAR_W | Barrier index (one extra bit so that out-of-range values can occur) |
| opTarget | input | PC_W | Branch target PC |
| opTaken | input | THREADS | Per-thread branch-taken bits |
| groupValid | output | 1 | At least one thread is ready |
| groupPc | output | PC_W | PC of the selected thread group |
| execMask | output | THREADS | Threads of the selected group |
| readyMask | output | THREADS | Threads not blocked on a barrier |
| errFlag | output | 1 | Sticky barrier-misuse flag |

## Verification
The bench builds the block with 8 threads, 4 barriers, 8-bit PCs and a 3-bit barrier index. With these values, indices 4 to 7 exercise the out-of-range error, and a nested two-level divergence can form three separate groups at once. The 8-bit PC also lets long random runs wrap the program counter. A scripted nested if/else with overlapping barriers is followed by random operations with periodic resets. These random runs reach the cases of full blocking, simultaneous release and an add that lands on a releasing barrier.

// File: rtl/reconv_pkg.sv
package reconv_pkg;

  typedef enum logic [1:0] {
    OP_STEP   = 2'd0,
    OP_BRANCH = 2'd1,
    OP_ADD    = 2'd2,
    OP_WAIT   = 2'd3
  } opCode_e;

  // strobes from control to datapath for the PC update
  typedef struct packed {
    logic pcStep;
    logic pcBranch;
  } pcCtrl_t;

endpackage

// File: rtl/reconv_ctrl.sv
module reconv_ctrl
  import reconv_pkg::*;
#(
  parameter int THREADS  = 8,
  parameter int NUM_BARS = 4,
  parameter int BAR_W    = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic [1:0]         opCode,
  input  logic [BAR_W-1:0]   opBar,
  input  logic [THREADS-1:0] execMask,
  output pcCtrl_t            pcCtrl,
  output logic [THREADS-1:0] setBlock,
  output logic [THREADS-1:0] releaseMask,
  output logic               errFlag
);

  logic [THREADS-1:0]  partQ  [NUM_BARS];
  logic [THREADS-1:0]  arriveQ[NUM_BARS];
  logic [NUM_BARS-1:0] inUseQ;

  opCode_e             code;
  logic                inRange;
  logic [NUM_BARS-1:0] addHit, waitHit, relHit;
  logic                waitMiss, errSet;

  assign code    = opCode_e'(opCode);
  assign inRange = {1'b0, opBar} < (BAR_W+1)'(NUM_BARS);

  assign pcCtrl.pcStep   = opValid && (code != OP_BRANCH);
  assign pcCtrl.pcBranch = opValid && (code == OP_BRANCH);

  always_comb begin
    setBlock    = '0;
    releaseMask = '0;
    waitMiss    = 1'b0;
    for (int b = 0; b < NUM_BARS; b++) begin
      addHit[b]  = opValid && (code == OP_ADD)  && (opBar == BAR_W'(b));
      waitHit[b] = opValid && (code == OP_WAIT) && (opBar == BAR_W'(b)) && inUseQ[b];
      relHit[b]  = inUseQ[b] && (arriveQ[b] == partQ[b]);
      if (opValid && (code == OP_WAIT) && (opBar == BAR_W'(b)) && !inUseQ[b])
        waitMiss = 1'b1;
      if (waitHit[b]) setBlock    = setBlock | (execMask & partQ[b]);
      if (relHit[b])  releaseMask = releaseMask | partQ[b];
    end
    errSet = waitMiss ||
             (opValid && ((code == OP_ADD) || (code == OP_WAIT)) && !inRange);
  end

  generate
    for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          partQ[b]   <= '0;
          arriveQ[b] <= '0;
          inUseQ[b]  <= 1'b0;
        end else if (addHit[b]) begin
          partQ[b]   <= execMask;
          arriveQ[b] <= '0;
          inUseQ[b]  <= 1'b1;
        end else begin
          if (relHit[b])  inUseQ[b]  <= 1'b0;
          if (waitHit[b]) arriveQ[b] <= arriveQ[b] | (execMask & partQ[b]);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       errFlag <= 1'b0;
    else if (errSet) errFlag <= 1'b1;
  end

endmodule

// File: rtl/reconv_datapath.sv
module reconv_datapath
  import reconv_pkg::*;
#(
  parameter int THREADS = 8,
  parameter int PC_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  pcCtrl_t            pcCtrl,
  input  logic [PC_W-1:0]    opTarget,
  input  logic [THREADS-1:0] opTaken,
  input  logic [THREADS-1:0] setBlock,
  input  logic [THREADS-1:0] releaseMask,
  output logic               groupValid,
  output logic [PC_W-1:0]    groupPc,
  output logic [THREADS-1:0] execMask,
  output logic [THREADS-1:0] readyMask
);

  logic [PC_W-1:0]    pcQ [THREADS];
  logic [THREADS-1:0] blockedQ;

  assign readyMask = ~blockedQ;

  // lowest ready thread wins: scan from the top so index 0 is written last
  always_comb begin
    groupPc    = '0;
    groupValid = 1'b0;
    for (int i = THREADS-1; i >= 0; i--) begin
      if (!blockedQ[i]) begin
        groupPc    = pcQ[i];
        groupValid = 1'b1;
      end
    end
    for (int i = 0; i < THREADS; i++)
      execMask[i] = !blockedQ[i] && (pcQ[i] == groupPc);
  end

  generate
    for (genvar i = 0; i < THREADS; i++) begin : g_thr
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          pcQ[i] <= '0;
        else if (execMask[i] && pcCtrl.pcBranch && opTaken[i])
          pcQ[i] <= opTarget;
        else if (execMask[i] && (pcCtrl.pcStep || pcCtrl.pcBranch))
          pcQ[i] <= pcQ[i] + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blockedQ <= '0;
    else       blockedQ <= (blockedQ | setBlock) & ~releaseMask;
  end

endmodule

// File: rtl/reconv_unit.sv
module reconv_unit
  import reconv_pkg::*;
#(
  parameter int THREADS  = 8,
  parameter int NUM_BARS = 4,
  parameter int PC_W     = 8,
  localparam int BAR_W   = $clog2(NUM_BARS) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic [1:0]         opCode,
  input  logic [BAR_W-1:0]   opBar,
  input  logic [PC_W-1:0]    opTarget,
  input  logic [THREADS-1:0] opTaken,
  output logic               groupValid,
  output logic [PC_W-1:0]    groupPc,
  output logic [THREADS-1:0] execMask,
  output logic [THREADS-1:0] readyMask,
  output logic               errFlag
);

  pcCtrl_t            pcCtrl;
  logic [THREADS-1:0] setBlock;
  logic [THREADS-1:0] releaseMask;

  reconv_ctrl #(.THREADS(THREADS), .NUM_BARS(NUM_BARS), .BAR_W(BAR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opBar(opBar),
    .execMask(execMask), .pcCtrl(pcCtrl), .setBlock(setBlock),
    .releaseMask(releaseMask), .errFlag(errFlag)
  );

  reconv_datapath #(.THREADS(THREADS), .PC_W(PC_W)) u_dp (
    .clk(clk), .rstN(rstN), .pcCtrl(pcCtrl), .opTarget(opTarget),
    .opTaken(opTaken), .setBlock(setBlock), .releaseMask(releaseMask),
    .groupValid(groupValid), .groupPc(groupPc), .execMask(execMask),
    .readyMask(readyMask)
  );

endmodule

// File: rtl/reconv_unit_chk.sv
module reconv_unit_chk #(
  parameter int THREADS  = 8,
  parameter int NUM_BARS = 4,
  parameter int BAR_W    = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               opValid,
  input logic [1:0]         opCode,
  input logic [BAR_W-1:0]   opBar,
  input logic               groupValid,
  input logic [THREADS-1:0] execMask,
  input logic [THREADS-1:0] readyMask,
  input logic               errFlag
);

  p_group_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    groupValid == (readyMask != '0));

  p_none_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (readyMask == '0) |-> (execMask == '0));

  p_exec_is_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (execMask & ~readyMask) == '0);

  p_only_wait_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || (opCode != 2'd3)) |=> (($past(readyMask) & ~readyMask) == '0));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  p_bad_index_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode[1] && ({1'b0, opBar} >= (BAR_W+1)'(NUM_BARS))) |=> errFlag);

  p_idle_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(errFlag));

endmodule

bind reconv_unit reconv_unit_chk #(.THREADS(THREADS), .NUM_BARS(NUM_BARS), .BAR_W(BAR_W)) chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opBar(opBar),
  .groupValid(groupValid), .execMask(execMask), .readyMask(readyMask),
  .errFlag(errFlag)
);

// File: tb/reconv_unit_test.sv
module reconv_unit_test;
  localparam int T  = 8;
  localparam int NB = 4;
  localparam int PW = 8;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [1:0] opCode = '0;
  logic [BW-1:0] opBar = '0;
  logic [PW-1:0] opTarget = '0;
  logic [T-1:0] opTaken = '0;
  logic groupValid, errFlag;
  logic [PW-1:0] groupPc;
  logic [T-1:0] execMask, readyMask;

  reconv_unit #(.THREADS(T), .NUM_BARS(NB), .PC_W(PW)) uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opBar(opBar),
    .opTarget(opTarget), .opTaken(opTaken), .groupValid(groupValid),
    .groupPc(groupPc), .execMask(execMask), .readyMask(readyMask), .errFlag(errFlag)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  string curTag = "R1";
  bit done = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  // ---------------- behavioural reference model ----------------
  int  mPc [T];
  int  mBlk;
  int  mPart [NB];
  int  mArr [NB];
  bit  mUse [NB];
  bit  mErr;
  bit  modelLive = 0;

  task automatic modelGroup(output int gv, output int gp, output int em);
    gv = 0; gp = 0; em = 0;
    for (int i = 0; i < T; i++)
      if (!mBlk[i] && gv == 0) begin gv = 1; gp = mPc[i]; end
    for (int i = 0; i < T; i++)
      if (!mBlk[i] && mPc[i] == gp) em |= (1 << i);
  endtask

  always @(posedge clk) begin
    int gv, gp, em, rel, setB, bar, code;
    bit oldUse [NB];
    bit relB [NB];
    modelLive <= rstN;
    if (!rstN) begin
      for (int i = 0; i < T; i++) mPc[i] = 0;
      for (int b = 0; b < NB; b++) begin mPart[b] = 0; mArr[b] = 0; mUse[b] = 0; end
      mBlk = 0; mErr = 0;
    end else begin
      modelGroup(gv, gp, em);
      rel = 0; setB = 0;
      for (int b = 0; b < NB; b++) begin
        oldUse[b] = mUse[b];
        relB[b] = mUse[b] && (mArr[b] == mPart[b]);
        if (relB[b]) rel |= mPart[b];
      end
      bar = int'(opBar); code = int'(opCode);
      for (int b = 0; b < NB; b++) if (relB[b]) mUse[b] = 0;
      if (opValid) begin
        if ((code == 2 || code == 3) && bar >= NB) mErr = 1;
        if (code == 3 && bar < NB && !oldUse[bar]) mErr = 1;
        for (int i = 0; i < T; i++)
          if (em[i]) begin
            if (code == 1 && opTaken[i]) mPc[i] = int'(opTarget);
            else mPc[i] = (mPc[i] + 1) % (1 << PW);
          end
        if (code == 2 && bar < NB) begin
          mUse[bar] = 1; mPart[bar] = em; mArr[bar] = 0;
        end
        if (code == 3 && bar < NB && oldUse[bar]) begin
          setB = em & mPart[bar];
          mArr[bar] |= setB;
        end
      end
      mBlk = (mBlk | setB) & ~rel & ((1 << T) - 1);
    end
  end

  always @(negedge clk) begin
    int gv, gp, em;
    if (rstN && modelLive) begin
      modelGroup(gv, gp, em);
      chk(curTag, "groupValid", int'(groupValid), gv);
      chk(curTag, "groupPc", int'(groupPc), gp);
      chk(curTag, "execMask", int'(execMask), em);
      chk(curTag, "readyMask", int'(readyMask), ~mBlk & ((1 << T) - 1));
      chk(curTag, "errFlag", int'(errFlag), int'(mErr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input int code, input int bar, input int tgt, input int taken);
    @(negedge clk);
    opValid = 1'b1; opCode = code[1:0]; opBar = bar[BW-1:0];
    opTarget = tgt[PW-1:0]; opTaken = taken[T-1:0];
    @(posedge clk); #1;
    opValid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    opValid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; opValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic look(input string tag, input int gv, input int gp, input int em, input int rdy, input int er);
    chk(tag, "groupValid", int'(groupValid), gv);
    chk(tag, "groupPc", int'(groupPc), gp);
    chk(tag, "execMask", int'(execMask), em);
    chk(tag, "readyMask", int'(readyMask), rdy);
    chk(tag, "errFlag", int'(errFlag), er);
  endtask

  initial begin
    doReset();
    curTag = "R1";
    look("R1", 1, 0, 'hFF, 'hFF, 0);

    curTag = "R3";
    issue(0, 0, 0, 0); issue(0, 0, 0, 0);
    look("R3", 1, 2, 'hFF, 'hFF, 0);

    curTag = "R5";
    issue(2, 0, 0, 0);                 // barrier 0 gets all threads
    look("R5", 1, 3, 'hFF, 'hFF, 0);

    curTag = "R4";
    issue(1, 0, 10, 'hAA);             // odd threads to 10, evens fall through
    look("R4", 1, 4, 'h55, 'hFF, 0);

    curTag = "R6";
    issue(0, 0, 0, 0);
    issue(3, 0, 0, 0);                 // evens wait on barrier 0
    look("R6", 1, 10, 'hAA, 'hAA, 0);

    curTag = "R4";
    issue(2, 1, 0, 0);                 // odds add barrier 1
    issue(1, 0, 20, 'h02);             // thread 1 to 20, others to 12
    look("R4", 1, 20, 'h02, 'hAA, 0);

    curTag = "R6";
    issue(0, 0, 0, 0);
    issue(3, 1, 0, 0);                 // thread 1 waits
    look("R6", 1, 12, 'hA8, 'hA8, 0);

    curTag = "R2";
    issue(3, 1, 0, 0);                 // last arrivals of barrier 1
    look("R2", 0, 0, 'h00, 'h00, 0);

    curTag = "R8";
    idle();                            // release of barrier 1
    look("R8", 1, 22, 'h02, 'hAA, 0);

    issue(1, 0, 13, 'hFF);             // thread 1 rejoins at 13
    look("R2", 1, 13, 'hAA, 'hAA, 0);
    issue(3, 0, 0, 0);                 // odds complete barrier 0
    look("R8", 0, 0, 'h00, 'h00, 0);
    idle();
    look("R8", 1, 6, 'h55, 'hFF, 0);

    curTag = "R7";
    issue(2, 2, 0, 0);                 // barrier 2 for evens only
    issue(1, 0, 14, 'hFF);             // evens join odds at 14
    look("R7", 1, 14, 'hFF, 'hFF, 0);
    issue(3, 2, 0, 0);                 // odds are not participants
    look("R7", 1, 15, 'hAA, 'hAA, 0);
    idle();
    look("R8", 1, 15, 'hFF, 'hFF, 0);

    curTag = "R9";
    issue(3, 3, 0, 0);                 // wait on a barrier never added
    look("R9", 1, 16, 'hFF, 'hFF, 1);
    issue(2, 5, 0, 0);                 // out-of-range add
    issue(3, 6, 0, 0);                 // out-of-range wait
    look("R9", 1, 18, 'hFF, 'hFF, 1);

    curTag = "R10";
    @(negedge clk);
    opValid = 1'b0; opCode = 2'd1; opBar = 3'd0; opTarget = 8'h77; opTaken = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    look("R10", 1, 18, 'hFF, 'hFF, 1);

    curTag = "R1";
    doReset();
    look("R1", 1, 0, 'hFF, 'hFF, 0);

    curTag = "R2";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (n % 250 == 249) begin
        rstN = 1'b0; opValid = 1'b0;
        @(negedge clk);
        rstN = 1'b1;
      end
      opValid  = ($urandom % 4) != 0;
      opCode   = 2'($urandom % 4);
      opBar    = 3'($urandom % 5);
      opTarget = 8'($urandom % 24);
      opTaken  = 8'($urandom);
    end
    @(negedge clk); opValid = 1'b0;
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule